// File: doc/BRIEF.md
# Frame Reception Policy Filter

This block sits at the front of a link-layer receiver and decides what happens to each arriving frame, using only the frame's 8-bit type code. A 32-bit policy register holds a 2-bit policy field for each of fourteen known type codes. A separate field covers every other type code. Each policy gives one of three outcomes. The frame is accepted, rejected, or held until the host makes the call. The block handles no frame payload.

A frame is offered with a valid strobe and its type code. It is taken when the block is ready, and the verdict appears one cycle later as a single-cycle decision pulse. A held frame makes the block busy, and new frames are back-pressured until the frame is released. Three things release it. The host can write a self-clearing accept bit, or a self-clearing reject bit, to the control set address. A sticky auto-accept bit also releases it. The auto-accept bit is raised through a write-1-to-set address and lowered through a write-1-to-clear address.

Top module: `rx_frame_policy`

## Requirements
- R1: After reset, `cfgRdata` reads 0x1000_1555, `ctlRdata` reads 0, `busy` is 0, `frmReady` is 1 and `decValid` is 0.
- R2: A frame is taken on a cycle with `frmValid` and `frmReady` both high. The verdict is shown on `decValid`/`decKind` in the following cycle, with `decKind` 00 = accept, 01 = reject, 10 = held. Policy code 00 gives accept, 01 gives reject and 11 gives reject.
- R3: The policy fields are at these positions (type code to field LSB): 0x27 at 28, 0x34 at 26, 0x39 at 24, 0x41 at 22, 0x46 at 20, 0x58 at 18, 0x5F at 16, 0xA1 at 14, 0xA6 at 12, 0xB8 at 10, 0xBF at 8, 0xC7 at 6, 0xD4 at 4, 0xD9 at 2.
- R4: Any type code not listed in R3 uses the field at bits 1:0.
- R5: A write with `cfgWe` replaces the policy register. Bits 31:30 are forced to 0 and always read 0.
- R6: Policy code 10 with auto-accept off gives a held verdict. `busy` then stays 1 and `frmReady` stays 0 until the frame is released.
- R7: While a frame is held, a set-address write with bit 1 gives an accept verdict in the next cycle. A set-address write with bit 2 gives a reject verdict. Either write returns `busy` to 0.
- R8: If bits 1 and 2 are written together while a frame is held, the verdict is reject.
- R9: Bits 1 and 2 are self-clearing: they always read 0, and writing them when nothing is held has no effect.
- R10: Control bit 0 (auto-accept) is set through `ctlSetWe` and cleared through `ctlClrWe`, and reads back on `ctlRdata[0]`. If both addresses write it in the same cycle, the clear wins.
- R11: With auto-accept set, a frame with policy 10 is accepted at once. If auto-accept is set while a frame is held, the accept verdict follows one cycle after the bit reads back as 1.
- R12: While `busy` is 1, offered frames are not taken and produce no decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| frmValid | input | 1 | Frame start strobe |
| frmType | input | 8 | Type code of the offered frame |
| frmReady | output | 1 | Block can take a frame |
| busy | output | 1 | A frame is held for a release |
| decValid | output | 1 | Decision pulse |
| decKind | output | 2 | 00 accept, 01 reject, 10 held |
| cfgWe | input | 1 | Policy register write |
| cfgWdata | input | 32 | Policy register write data |
| cfgRdata | output | 32 | Policy register value |
| ctlSetWe | input | 1 | Control write-1-to-set strobe |
| ctlClrWe | input | 1 | Control write-1-to-clear strobe |
| ctlWdata | input | 3 | Control write data (bit0 auto, bit1 accept, bit2 reject) |
| ctlRdata | output | 3 | Control value (bit0 auto-accept) |

## Verification
Three pairs of events can fall in the same cycle. The host accept and host reject releases are provoked together by one set-address write carrying both bits, and the bench expects a reject verdict. Setting and clearing auto-accept in the same cycle is judged by the read-back value, which must be 0. A new frame is offered throughout a hold. The bench expects no decision and a low `frmReady` until the release edge. After that edge, the next frame is decided normally.

// File: rtl/rfp_pkg.sv
package rfp_pkg;
  localparam int TYPE_W    = 8;
  localparam int CFG_W     = 32;
  localparam int NUM_KNOWN = 14;
  localparam int CTL_W     = 3;
  localparam int CTL_AUTO  = 0;
  localparam int CTL_ACC   = 1;
  localparam int CTL_REJ   = 2;

  localparam logic [CFG_W-1:0] CFG_RESET = 32'h1000_1555;
  localparam logic [CFG_W-1:0] CFG_MASK  = 32'h3FFF_FFFF;

  typedef enum logic [1:0] {
    POL_ACCEPT = 2'b00,
    POL_REJECT = 2'b01,
    POL_HOLD   = 2'b10,
    POL_RSVD   = 2'b11
  } policy_t;

  localparam logic [1:0] DEC_ACCEPT = 2'b00;
  localparam logic [1:0] DEC_REJECT = 2'b01;
  localparam logic [1:0] DEC_HOLD   = 2'b10;

  typedef struct packed {
    logic emitAccept;
    logic emitReject;
    logic emitHold;
  } emit_t;

  // Known type code for table slot idx; slot idx owns field LSB 2*(NUM_KNOWN-idx).
  function automatic logic [TYPE_W-1:0] knownType(input int idx);
    case (idx)
      0:       return 8'h27;
      1:       return 8'h34;
      2:       return 8'h39;
      3:       return 8'h41;
      4:       return 8'h46;
      5:       return 8'h58;
      6:       return 8'h5F;
      7:       return 8'hA1;
      8:       return 8'hA6;
      9:       return 8'hB8;
      10:      return 8'hBF;
      11:      return 8'hC7;
      12:      return 8'hD4;
      default: return 8'hD9;
    endcase
  endfunction
endpackage

// File: rtl/rfp_policy_dp.sv
module rfp_policy_dp
  import rfp_pkg::*;
#(
  parameter int NK = NUM_KNOWN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TYPE_W-1:0] frmType,
  input  logic              cfgWe,
  input  logic [CFG_W-1:0]  cfgWdata,
  input  logic              ctlSetWe,
  input  logic              ctlClrWe,
  input  logic [CTL_W-1:0]  ctlWdata,
  input  emit_t             emit,
  output logic [CFG_W-1:0]  cfgRdata,
  output logic [CTL_W-1:0]  ctlRdata,
  output policy_t           policy,
  output logic              autoAccept,
  output logic              relAccept,
  output logic              relReject,
  output logic              decValid,
  output logic [1:0]        decKind
);
  logic [CFG_W-1:0] cfgReg;
  logic             autoReg;
  logic [NK-1:0]    hit;
  logic [1:0]       field [NK];
  logic [1:0]       polRaw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfgReg <= CFG_RESET;
    else if (cfgWe) cfgReg <= cfgWdata & CFG_MASK;
  end

  // Set first, clear applied last so clear wins on a same-cycle collision.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) autoReg <= 1'b0;
    else begin
      if (ctlSetWe && ctlWdata[CTL_AUTO]) autoReg <= 1'b1;
      if (ctlClrWe && ctlWdata[CTL_AUTO]) autoReg <= 1'b0;
    end
  end

  genvar g;
  generate
    for (g = 0; g < NK; g++) begin : gLookup
      localparam int LSB = 2 * (NK - g);
      assign hit[g]   = (frmType == knownType(g));
      assign field[g] = cfgReg[LSB +: 2];
    end
  endgenerate

  always_comb begin
    polRaw = cfgReg[1:0];
    for (int i = 0; i < NK; i++)
      if (hit[i]) polRaw = field[i];
  end

  assign policy     = policy_t'(polRaw);
  assign autoAccept = autoReg;
  assign relAccept  = ctlSetWe && ctlWdata[CTL_ACC];
  assign relReject  = ctlSetWe && ctlWdata[CTL_REJ];
  assign cfgRdata   = cfgReg;
  assign ctlRdata   = {{(CTL_W-1){1'b0}}, autoReg};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      decValid <= 1'b0;
      decKind  <= DEC_ACCEPT;
    end else begin
      decValid <= emit.emitAccept || emit.emitReject || emit.emitHold;
      decKind  <= emit.emitReject ? DEC_REJECT :
                  emit.emitHold   ? DEC_HOLD   : DEC_ACCEPT;
    end
  end

  // R2: the controller never asks for two verdicts at once
  a_r2_single_emit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({emit.emitAccept, emit.emitReject, emit.emitHold}));
  // R2: every requested verdict shows on the decision output next cycle
  a_r2_emit_shown: assert property (@(posedge clk) disable iff (!rst_n)
    (emit.emitAccept || emit.emitReject || emit.emitHold) |=> decValid);
  // R5: policy register only moves on a write
  a_r5_cfg_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !cfgWe |=> $stable(cfgRdata));
  // R8: a reject request is never shown as accept
  a_r8_reject_shown: assert property (@(posedge clk) disable iff (!rst_n)
    emit.emitReject |=> (decKind == DEC_REJECT));
endmodule

// File: rtl/rfp_hold_ctl.sv
module rfp_hold_ctl
  import rfp_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    frmValid,
  input  policy_t policy,
  input  logic    autoAccept,
  input  logic    relAccept,
  input  logic    relReject,
  output logic    frmReady,
  output logic    busy,
  output emit_t   emit
);
  typedef enum logic {ST_IDLE, ST_HELD} state_t;
  state_t state, stateNext;

  always_comb begin
    emit      = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: if (frmValid) begin
        unique case (policy)
          POL_ACCEPT: emit.emitAccept = 1'b1;
          POL_HOLD: begin
            if (autoAccept) emit.emitAccept = 1'b1;
            else begin
              emit.emitHold = 1'b1;
              stateNext     = ST_HELD;
            end
          end
          default: emit.emitReject = 1'b1;
        endcase
      end
      ST_HELD: begin
        if (relReject) begin
          emit.emitReject = 1'b1;
          stateNext       = ST_IDLE;
        end else if (relAccept || autoAccept) begin
          emit.emitAccept = 1'b1;
          stateNext       = ST_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  assign frmReady = (state == ST_IDLE);
  assign busy     = (state == ST_HELD);

  // R6: a held frame stays held until some release arrives
  a_r6_stay_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !relAccept && !relReject && !autoAccept) |=> busy);
  // R7: any host release ends the hold at once
  a_r7_release_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (relAccept || relReject)) |=> !busy);
  // R11: with auto-accept on, a taken frame never becomes held
  a_r11_auto_no_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (frmValid && frmReady && autoAccept) |=> !busy);
endmodule

// File: rtl/rx_frame_policy.sv
module rx_frame_policy
  import rfp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frmValid,
  input  logic [7:0]  frmType,
  output logic        frmReady,
  output logic        busy,
  output logic        decValid,
  output logic [1:0]  decKind,
  input  logic        cfgWe,
  input  logic [31:0] cfgWdata,
  output logic [31:0] cfgRdata,
  input  logic        ctlSetWe,
  input  logic        ctlClrWe,
  input  logic [2:0]  ctlWdata,
  output logic [2:0]  ctlRdata
);
  emit_t   emit;
  policy_t policy;
  logic    autoAccept, relAccept, relReject;

  rfp_policy_dp #(.NK(NUM_KNOWN)) dp_i (
    .clk(clk), .rst_n(rst_n), .frmType(frmType),
    .cfgWe(cfgWe), .cfgWdata(cfgWdata),
    .ctlSetWe(ctlSetWe), .ctlClrWe(ctlClrWe), .ctlWdata(ctlWdata),
    .emit(emit), .cfgRdata(cfgRdata), .ctlRdata(ctlRdata),
    .policy(policy), .autoAccept(autoAccept),
    .relAccept(relAccept), .relReject(relReject),
    .decValid(decValid), .decKind(decKind)
  );

  rfp_hold_ctl ctl_i (
    .clk(clk), .rst_n(rst_n), .frmValid(frmValid), .policy(policy),
    .autoAccept(autoAccept), .relAccept(relAccept), .relReject(relReject),
    .frmReady(frmReady), .busy(busy), .emit(emit)
  );
endmodule

// File: tb/rx_frame_policy_tb_top.sv
module rx_frame_policy_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frmValid = 1'b0;
  logic [7:0]  frmType = 8'h00;
  logic        frmReady, busy, decValid;
  logic [1:0]  decKind;
  logic        cfgWe = 1'b0;
  logic [31:0] cfgWdata = '0;
  logic [31:0] cfgRdata;
  logic        ctlSetWe = 1'b0, ctlClrWe = 1'b0;
  logic [2:0]  ctlWdata = '0;
  logic [2:0]  ctlRdata;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  logic [7:0] typeTab [14] = '{8'h27, 8'h34, 8'h39, 8'h41, 8'h46, 8'h58, 8'h5F,
                               8'hA1, 8'hA6, 8'hB8, 8'hBF, 8'hC7, 8'hD4, 8'hD9};

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_frame_policy dut_i (
    .clk(clk), .rst_n(rst_n), .frmValid(frmValid), .frmType(frmType),
    .frmReady(frmReady), .busy(busy), .decValid(decValid), .decKind(decKind),
    .cfgWe(cfgWe), .cfgWdata(cfgWdata), .cfgRdata(cfgRdata),
    .ctlSetWe(ctlSetWe), .ctlClrWe(ctlClrWe), .ctlWdata(ctlWdata),
    .ctlRdata(ctlRdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Offer one frame for one cycle; check the verdict in the following cycle.
  task automatic sendFrame(input logic [7:0] t, input bit expValid,
                           input logic [1:0] expKind, input string req);
    @(negedge clk);
    frmValid = 1'b1; frmType = t;
    @(negedge clk);
    frmValid = 1'b0;
    chk(decValid == expValid, req, decValid, expValid);
    if (expValid) chk(decKind == expKind, req, decKind, expKind);
  endtask

  task automatic writeCfg(input logic [31:0] v);
    @(negedge clk);
    cfgWe = 1'b1; cfgWdata = v;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic writeCtl(input bit setW, input bit clrW, input logic [2:0] v);
    @(negedge clk);
    ctlSetWe = setW; ctlClrWe = clrW; ctlWdata = v;
    @(negedge clk);
    ctlSetWe = 1'b0; ctlClrWe = 1'b0; ctlWdata = '0;
  endtask

  task automatic tReset();
    chk(cfgRdata == 32'h1000_1555, "R1 cfg", cfgRdata, 32'h1000_1555);
    chk(ctlRdata == 3'd0, "R1 ctl", ctlRdata, 0);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(frmReady == 1'b1, "R1 ready", frmReady, 1);
    chk(decValid == 1'b0, "R1 decValid", decValid, 0);
  endtask

  task automatic tDefaults();
    sendFrame(8'h27, 1, 2'b01, "R3 default 0x27 reject");
    sendFrame(8'h34, 1, 2'b00, "R3 default 0x34 accept");
    sendFrame(8'hA1, 1, 2'b00, "R3 default 0xA1 accept");
    sendFrame(8'hA6, 1, 2'b01, "R3 default 0xA6 reject");
    sendFrame(8'h00, 1, 2'b01, "R4 default unlisted reject");
  endtask

  task automatic tFields();
    for (int i = 0; i < 14; i++) begin
      logic [31:0] v;
      v = 32'h1555_5555 & ~(32'h3 << (28 - 2*i));
      writeCfg(v);
      sendFrame(typeTab[i], 1, 2'b00, "R3 field position accept");
      sendFrame(8'h50, 1, 2'b01, "R4 unlisted stays reject");
    end
    writeCfg(32'h1555_5554);
    sendFrame(8'h99, 1, 2'b00, "R4 default field accept");
    sendFrame(8'h27, 1, 2'b01, "R4 listed type ignores default");
    writeCfg(32'hFFFF_FFFF);
    chk(cfgRdata == 32'h3FFF_FFFF, "R5 reserved bits read 0", cfgRdata, 32'h3FFF_FFFF);
    sendFrame(8'h46, 1, 2'b01, "R2 code 11 listed reject");
    sendFrame(8'h10, 1, 2'b01, "R2 code 11 default reject");
  endtask

  task automatic enterHold();
    writeCfg(32'h1000_1555 | (32'h2 << 20));
    sendFrame(8'h46, 1, 2'b10, "R6 held verdict");
    chk(busy == 1'b1, "R6 busy", busy, 1);
    chk(frmReady == 1'b0, "R6 ready low", frmReady, 0);
  endtask

  task automatic tHoldAccept();
    enterHold();
    @(negedge clk);
    frmValid = 1'b1; frmType = 8'h34;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(decValid == 1'b0, "R12 no decision while busy", decValid, 0);
      chk(frmReady == 1'b0, "R12 ready low while busy", frmReady, 0);
    end
    frmValid = 1'b0;
    writeCtl(1, 0, 3'b010);
    chk(decValid == 1'b1 && decKind == 2'b00, "R7 host accept",
        {decValid, decKind}, 3'b100);
    chk(busy == 1'b0, "R7 busy cleared", busy, 0);
    sendFrame(8'h34, 1, 2'b00, "R12 frame taken after release");
  endtask

  task automatic tHoldReject();
    enterHold();
    writeCtl(1, 0, 3'b100);
    chk(decValid == 1'b1 && decKind == 2'b01, "R7 host reject",
        {decValid, decKind}, 3'b101);
    chk(busy == 1'b0, "R7 busy cleared after reject", busy, 0);
  endtask

  task automatic tBoth();
    enterHold();
    writeCtl(1, 0, 3'b110);
    chk(decValid == 1'b1 && decKind == 2'b01, "R8 reject wins",
        {decValid, decKind}, 3'b101);
    chk(busy == 1'b0, "R8 busy cleared", busy, 0);
  endtask

  task automatic tIdlePulse();
    writeCtl(1, 0, 3'b110);
    chk(decValid == 1'b0, "R9 no decision when idle", decValid, 0);
    chk(busy == 1'b0, "R9 stays idle", busy, 0);
    chk(ctlRdata == 3'd0, "R9 pulse bits read 0", ctlRdata, 0);
    sendFrame(8'h34, 1, 2'b00, "R9 later frame unaffected");
  endtask

  task automatic tAuto();
    writeCtl(1, 0, 3'b001);
    chk(ctlRdata == 3'd1, "R10 auto set", ctlRdata, 1);
    writeCtl(1, 1, 3'b001);
    chk(ctlRdata == 3'd0, "R10 clear wins", ctlRdata, 0);
    writeCtl(1, 0, 3'b001);
    writeCfg(32'h1000_1555 | (32'h2 << 20));
    sendFrame(8'h46, 1, 2'b00, "R11 auto accept immediate");
    chk(busy == 1'b0, "R11 no hold with auto", busy, 0);
    writeCtl(0, 1, 3'b001);
    chk(ctlRdata == 3'd0, "R10 auto cleared", ctlRdata, 0);
    sendFrame(8'h46, 1, 2'b10, "R11 hold with auto off");
    writeCtl(1, 0, 3'b001);
    chk(ctlRdata == 3'd1 && busy == 1'b1 && decValid == 1'b0,
        "R11 auto visible, still held", {ctlRdata, busy, decValid}, 5'b00110);
    @(negedge clk);
    chk(decValid == 1'b1 && decKind == 2'b00, "R11 auto releases held",
        {decValid, decKind}, 3'b100);
    chk(busy == 1'b0, "R11 busy cleared", busy, 0);
    writeCtl(0, 1, 3'b001);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tReset();
    tDefaults();
    tFields();
    tHoldAccept();
    tHoldReject();
    tBoth();
    tIdlePulse();
    tAuto();
    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule